// File: doc/BRIEF.md
# Rewrite-Kicked Watchdog Timer

This block is a countdown watchdog that software controls through one byte-wide configuration register on a simple register bus. The byte packs three things: a five-bit period count, a two-bit choice of countdown rate, and a steering bit. The rate choice picks one of four slow tick inputs that the chip supplies. Any write to the configuration register reloads the countdown from the written count, so software keeps the watchdog alive by rewriting the same byte. A count of zero leaves the watchdog idle.

When the countdown runs out, the block sets a watchdog flag in a separate status register. The steering bit then picks one of two responses: a reset pulse of fixed length in system clocks, or an interrupt level that stays up until software clears the flag. After it expires, the timer stays stopped until the next configuration write. A read of the configuration register returns the byte that was programmed, not the remaining count.

Top module: `wdt_kickreg`

## Requirements
- R1: After reset the configuration byte and the status flag are zero, both wdt_rst_o and wdt_irq_o are low, and the timer is idle.
- R2: A write to address 0x1B stores the full byte. A read of 0x1B returns that byte unchanged while the countdown runs, and never the remaining count.
- R3: Configuration bits 1:0 select the rate tick: 00 uses tick_16hz, 01 uses tick_4hz, 10 uses tick_1hz and 11 uses tick_qhz. Pulses on the three unselected tick inputs do not advance the countdown.
- R4: Configuration bits 6:2 hold the period N, from 1 to 31. Expiry happens on the Nth selected tick after the load. The status flag reads as set from the clock edge that takes in that tick onward, and not before.
- R5: A period of zero disables the watchdog. No tick pattern sets the flag, raises wdt_irq_o or pulses wdt_rst_o.
- R6: Every write to 0x1B restarts the countdown from the written period. When a write and a selected tick arrive in the same cycle, the write wins and the tick is lost.
- R7: With configuration bit 7 set, expiry drives wdt_rst_o high for exactly RST_CYCLES consecutive clocks, starting at the expiry edge, and does not raise wdt_irq_o.
- R8: With configuration bit 7 clear, expiry raises wdt_irq_o, which stays high until the flag is cleared. wdt_rst_o stays low.
- R9: Status register 0x0F reports the watchdog flag in bit 6, and its other bits read as zero. A write to 0x0F with bit 6 clear clears the flag and wdt_irq_o. A write with bit 6 set leaves both unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R10: After expiry the timer stays stopped. Further selected ticks cause no second expiry until 0x1B is written again.
- R11: Writes to any address other than 0x1B and 0x0F change nothing, and reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| tick_16hz | input | 1 | One-clock pulse at rate code 00 |
| tick_4hz | input | 1 | One-clock pulse at rate code 01 |
| tick_1hz | input | 1 | One-clock pulse at rate code 10 |
| tick_qhz | input | 1 | One-clock pulse at rate code 11 |
| wdt_rst_o | output | 1 | Reset pulse on expiry when steering selects reset |
| wdt_irq_o | output | 1 | Interrupt level on expiry when steering selects interrupt |

## Verification
The bench drives a rewrite in the same cycle as a selected tick. A design that let the tick through would expire one tick early. It runs the full 31-period count on the slowest tick to expose off-by-one errors, and it sets the flag in the same cycle as a clearing write. A design that let the clear win there would lose the expiry without any sign. It also sends a stream of ticks after expiry and after a zero-period write. A design that wrapped its counter would fire again. Finally, it counts the length of the reset pulse and checks that steering keeps the two responses separate.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned RATE_W   = 2;
  localparam int unsigned SPAN_W   = 5;
  localparam int unsigned SPAN_LSB = RATE_W;
  localparam int unsigned STEER_BIT = SPAN_LSB + SPAN_W;
  localparam int unsigned FLAG_BIT = 6;
  localparam int unsigned N_RATES  = 1 << RATE_W;

  typedef enum logic [RATE_W-1:0] {
    RATE_16  = 2'b00,
    RATE_4   = 2'b01,
    RATE_1   = 2'b10,
    RATE_QTR = 2'b11
  } rate_e;

  typedef struct packed {
    logic              steer_rst;
    logic [SPAN_W-1:0] span;
    rate_e             rate;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_rate_sel.sv
module wdt_rate_sel #(
  parameter int unsigned N_IN = 4,
  localparam int unsigned SEL_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  ticks,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_o
);
  logic [N_IN-1:0] hit;

  for (genvar i = 0; i < N_IN; i++) begin : g_lane
    assign hit[i] = ticks[i] & (sel == SEL_W'(i));
  end

  assign tick_o = |hit;
endmodule

// File: rtl/wdt_down.sv
module wdt_down #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en   = 1'b0;
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (step && (cnt_q != '0)) begin
      cnt_en   = 1'b1;
      cnt_d    = cnt_q - CNT_W'(1);
      expire_o = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned LEN = 4,
  localparam int unsigned PW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_o
);
  logic [PW-1:0] left_q, left_d;
  logic          left_en;

  always_comb begin
    left_en = 1'b0;
    left_d  = left_q;
    if (fire) begin
      left_en = 1'b1;
      left_d  = PW'(LEN);
    end else if (left_q != '0) begin
      left_en = 1'b1;
      left_d  = left_q - PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/wdt_kickreg.sv
module wdt_kickreg
  import wdt_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]  CFG_ADDR   = ADDR_W'('h1B),
  parameter logic [ADDR_W-1:0]  STAT_ADDR  = ADDR_W'('h0F),
  parameter int unsigned        RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              tick_16hz,
  input  logic              tick_4hz,
  input  logic              tick_1hz,
  input  logic              tick_qhz,
  output logic              wdt_rst_o,
  output logic              wdt_irq_o
);
  localparam int unsigned CNT_W = SPAN_W;

  logic               rst_sync_n;
  logic               cfg_wr, stat_wr, stat_clr;
  wdt_cfg_t           cfg_q;
  logic [N_RATES-1:0] tick_vec;
  logic               sel_tick;
  logic [CNT_W-1:0]   live_cnt;
  logic               expire;
  logic               steer;
  logic               flag_q, flag_d, irq_q, irq_d, stat_en;

  wdt_rst_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  assign cfg_wr   = bus_wr && (bus_addr == CFG_ADDR);
  assign stat_wr  = bus_wr && (bus_addr == STAT_ADDR);
  assign stat_clr = stat_wr && !bus_wdata[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cfg_q <= '0;
    else if (cfg_wr) cfg_q <= wdt_cfg_t'(bus_wdata);
  end

  assign steer    = cfg_q.steer_rst;
  assign tick_vec = {tick_qhz, tick_1hz, tick_4hz, tick_16hz};

  wdt_rate_sel #(.N_IN(N_RATES)) u_rate (
    .ticks  (tick_vec),
    .sel    (cfg_q.rate),
    .tick_o (sel_tick)
  );

  wdt_down #(.CNT_W(CNT_W)) u_down (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (cfg_wr),
    .load_val (bus_wdata[SPAN_LSB +: CNT_W]),
    .step     (sel_tick),
    .cnt_o    (live_cnt),
    .expire_o (expire)
  );

  always_comb begin
    stat_en = 1'b0;
    flag_d  = flag_q;
    irq_d   = irq_q;
    if (expire) begin
      stat_en = 1'b1;
      flag_d  = 1'b1;
      if (!steer) irq_d = 1'b1;
    end else if (stat_clr) begin
      stat_en = 1'b1;
      flag_d  = 1'b0;
      irq_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (stat_en) begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  wdt_pulse #(.LEN(RST_CYCLES)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fire    (expire && steer),
    .pulse_o (wdt_rst_o)
  );

  assign wdt_irq_o = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CFG_ADDR)       bus_rdata = cfg_q;
    else if (bus_addr == STAT_ADDR) bus_rdata[FLAG_BIT] = flag_q;
  end
endmodule

// File: rtl/wdt_kickreg_chk.sv
module wdt_kickreg_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [CNT_W-1:0] wdata_span,
  input logic [CNT_W-1:0] live_cnt,
  input logic             expire,
  input logic             steer,
  input logic             flag,
  input logic             irq_o,
  input logic             rst_o
);
  p_cfg_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (live_cnt == $past(wdata_span)));

  p_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt == '0 && !cfg_wr) |=> !expire);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && live_cnt != '0) |=>
      (live_cnt == $past(live_cnt) || live_cnt == $past(live_cnt) - CNT_W'(1)));

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (live_cnt == '0));

  p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag);

  p_rst_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> $past(expire && steer));
endmodule

bind wdt_kickreg wdt_kickreg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cfg_wr     (cfg_wr),
  .wdata_span (bus_wdata[6:2]),
  .live_cnt   (live_cnt),
  .expire     (expire),
  .steer      (steer),
  .flag       (flag_q),
  .irq_o      (wdt_irq_o),
  .rst_o      (wdt_rst_o)
);

// File: tb/sim_wdt_kickreg.sv
`timescale 1ns/1ps
module sim_wdt_kickreg;
  localparam int RST_LEN = 4;
  localparam logic [7:0] A_CFG  = 8'h1B;
  localparam logic [7:0] A_STAT = 8'h0F;

  logic       clk, rst_n, wr;
  logic [7:0] addr, wdata, rdata;
  logic       t16, t4, t1, tq;
  logic       rst_o, irq_o;
  int n_tests = 0;
  int n_fail  = 0;

  wdt_kickreg #(.RST_CYCLES(RST_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata),
    .tick_16hz(t16), .tick_4hz(t4), .tick_1hz(t1), .tick_qhz(tq),
    .wdt_rst_o(rst_o), .wdt_irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference, advanced once per clock
  int m_cfg, m_cnt, m_rst;
  bit m_flag, m_irq;

  always @(posedge clk) begin : model
    bit hit, fired;
    if (!rst_n) begin
      m_cfg = 0; m_cnt = 0; m_rst = 0; m_flag = 0; m_irq = 0;
    end else begin
      fired = 0;
      case (m_cfg % 4)
        0: hit = t16;
        1: hit = t4;
        2: hit = t1;
        default: hit = tq;
      endcase
      if (wr && addr == A_CFG) begin
        m_cfg = wdata;
        m_cnt = (wdata / 4) % 32;
      end else if (m_cnt > 0 && hit) begin
        m_cnt = m_cnt - 1;
        fired = (m_cnt == 0);
      end
      if (m_rst > 0) m_rst = m_rst - 1;
      if (fired) begin
        m_flag = 1;
        if (m_cfg >= 128) m_rst = RST_LEN;
        else m_irq = 1;
      end else if (wr && addr == A_STAT && !wdata[6]) begin
        m_flag = 0;
        m_irq  = 0;
      end
    end
  end

  function automatic int m_read(input logic [7:0] a);
    if (a == A_CFG)  return m_cfg;
    if (a == A_STAT) return m_flag ? 8'h40 : 8'h00;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp_v);
    n_tests++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic drive(input bit w, input logic [7:0] a, input logic [7:0] d,
                       input logic [3:0] tk);
    @(negedge clk);
    if (rst_n) begin
      chk("R7 reset pulse vs model", rst_o, (m_rst > 0) ? 1 : 0);
      chk("R8 interrupt vs model", irq_o, m_irq ? 1 : 0);
      chk("R2/R9/R11 read data vs model", rdata, m_read(addr));
    end
    wr = w; addr = a; wdata = d;
    {tq, t1, t4, t16} = tk;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 8'h00, 4'b0000);
  endtask

  task automatic rd_chk(input logic [7:0] a, input int exp_v, input string tag);
    drive(1'b0, a, 8'h00, 4'b0000);
    #1 chk(tag, rdata, exp_v);
  endtask

  task automatic ticks(input logic [3:0] tk, input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 8'h00, tk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int highs;
    rst_n = 1'b0; wr = 1'b0; addr = 8'h00; wdata = 8'h00;
    {tq, t1, t4, t16} = 4'b0000;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(4);

    // R1
    chk("R1 reset rst_o low", rst_o, 0);
    chk("R1 reset irq_o low", irq_o, 0);
    rd_chk(A_CFG, 8'h00, "R1 config zero after reset");
    rd_chk(A_STAT, 8'h00, "R1 flag clear after reset");

    // R2, R3, R4, R8: period 3 on the 16 Hz lane, interrupt steering
    drive(1'b1, A_CFG, 8'h0C, 4'b0000);
    rd_chk(A_CFG, 8'h0C, "R2 config read back");
    ticks(4'b1110, 6);
    rd_chk(A_STAT, 8'h00, "R3 unselected ticks ignored");
    ticks(4'b0001, 2);
    rd_chk(A_CFG, 8'h0C, "R2 read shows config not count");
    rd_chk(A_STAT, 8'h00, "R4 no expiry before Nth tick");
    ticks(4'b0001, 1);
    rd_chk(A_STAT, 8'h40, "R4 flag after Nth tick");
    chk("R8 irq raised on expiry", irq_o, 1);
    chk("R8 no reset pulse", rst_o, 0);

    // R10
    ticks(4'b0001, 5);
    drive(1'b1, A_STAT, 8'h00, 4'b0000);
    ticks(4'b0001, 5);
    rd_chk(A_STAT, 8'h00, "R10 stays stopped after expiry");
    chk("R9 clear drops irq", irq_o, 0);

    // R7: period 2 on the 1 Hz lane, reset steering
    drive(1'b1, A_CFG, 8'h8A, 4'b0000);
    ticks(4'b0100, 2);
    highs = 0;
    for (int i = 0; i < RST_LEN + 3; i++) begin
      drive(1'b0, 8'h00, 8'h00, 4'b0000);
      #1 if (rst_o) highs++;
    end
    chk("R7 reset pulse length", highs, RST_LEN);
    chk("R7 no irq with reset steering", irq_o, 0);
    rd_chk(A_STAT, 8'h40, "R9 flag set by reset-steered expiry");
    drive(1'b1, A_STAT, 8'h40, 4'b0000);
    rd_chk(A_STAT, 8'h40, "R9 write with bit 6 set keeps flag");
    drive(1'b1, A_STAT, 8'h00, 4'b0000);
    rd_chk(A_STAT, 8'h00, "R9 write with bit 6 clear clears");

    // R5
    drive(1'b1, A_CFG, 8'h03, 4'b0000);
    ticks(4'b1111, 20);
    drive(1'b1, A_CFG, 8'h80, 4'b0000);
    ticks(4'b1111, 20);
    rd_chk(A_STAT, 8'h00, "R5 zero period never expires");
    chk("R5 no irq", irq_o, 0);
    chk("R5 no reset", rst_o, 0);

    // R6: period 2 on the 4 Hz lane, rewrite collides with a tick
    drive(1'b1, A_CFG, 8'h09, 4'b0000);
    ticks(4'b0010, 1);
    drive(1'b1, A_CFG, 8'h09, 4'b0010);
    ticks(4'b0010, 1);
    rd_chk(A_STAT, 8'h00, "R6 rewrite reloaded the period");
    ticks(4'b0010, 1);
    rd_chk(A_STAT, 8'h40, "R6 expiry after full reloaded period");
    drive(1'b1, A_STAT, 8'h00, 4'b0000);

    // R11
    drive(1'b1, 8'h1C, 8'hFF, 4'b0000);
    drive(1'b1, 8'h00, 8'hFF, 4'b0000);
    rd_chk(A_CFG, 8'h09, "R11 config untouched by other address");
    rd_chk(8'h1C, 8'h00, "R11 other address reads zero");
    rd_chk(A_STAT, 8'h00, "R11 flag untouched by other address");

    // R4 maximum period on the quarter-hertz lane
    drive(1'b1, A_CFG, 8'h7F, 4'b0000);
    ticks(4'b1000, 30);
    rd_chk(A_STAT, 8'h00, "R4 max period not early");
    ticks(4'b1000, 1);
    rd_chk(A_STAT, 8'h40, "R4 max period expires at 31");
    drive(1'b1, A_STAT, 8'h00, 4'b0000);

    // R9 expiry beats a same-cycle clear
    drive(1'b1, A_CFG, 8'h07, 4'b0000);
    drive(1'b1, A_STAT, 8'h00, 4'b1000);
    rd_chk(A_STAT, 8'h40, "R9 set wins over clear");
    chk("R9 irq held with flag", irq_o, 1);

    idle(4);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule